// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block collects eight level-sensitive interrupt lines and decides which one, if any, the processor should service. It keeps a status register (global enable, nesting flag, user-mode flag and an eight-bit mask) and a cause register that mirrors the sampled lines. A source is a candidate only when its line is active and its mask bit is set. When candidates exist and the global enable is on, the block raises a request and reports the highest-numbered candidate.

The processor acknowledges with a `take` strobe. The block then saves the current mask on an internal stack and narrows the mask so that only sources numbered above the one taken can interrupt. A `ret` strobe pops the stack and restores the mask that was in force before the matching entry. Nesting is therefore possible only towards higher priority. A return with nothing saved changes nothing and sets a sticky error flag. Software sets up the mask, enable and user-mode bits through a status write port.

Top module: `irq_prio_ctrl`

## Requirements
- R1: While reset is asserted and after its release, `irq_req`, `irq_id`, `status_q`, `cause_q` and `ret_err` are all zero.
- R2: `cause_q[15:8]` shows the value of `irq_lines` from the previous clock edge; `cause_q[7:0]` is always zero.
- R3: `irq_req` is 1 exactly when status bit 0 (enable) is 1 and `cause_q[15:8] & status_q[15:8]` is nonzero. With enable at 0, no request is made.
- R4: In the cycle after a cycle with `irq_req` high, `irq_id` holds the highest-numbered candidate of that earlier cycle. After a cycle without a request, `irq_id` keeps its value.
- R5: A `take` while `irq_req` is 1 and `ret` is 0 pushes the mask. The mask then keeps only the bits numbered above the selected source, status bit 0 becomes 1 and status bit 1 (nesting flag) becomes 1.
- R6: A `take` with `irq_req` at 0, or with eight masks already saved, has no effect on the status register.
- R7: A `ret` with at least one saved mask restores the most recently saved mask and sets status bit 0 to 1. Status bit 1 is cleared when no saved mask remains.
- R8: A `ret` with no saved mask leaves the status register unchanged and sets `ret_err`, which stays 1 until reset.
- R9: A status write loads the mask from `status_wdata[15:8]`, the enable from bit 0 and the user-mode flag (status bit 4) from bit 4. All other bits are ignored, and status bits 7:5, 3:2 read zero. `ret` takes precedence over an accepted `take`, which takes precedence over a write; the losing operations are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines | input | 8 | Level interrupt lines, sampled every cycle |
| status_we | input | 1 | Status register write strobe |
| status_wdata | input | 16 | Status write data |
| take | input | 1 | Processor accepts the current request |
| ret | input | 1 | Processor returns from the current handler |
| irq_req | output | 1 | Interrupt request |
| irq_id | output | 3 | Registered index of the selected source |
| status_q | output | 16 | Status register contents |
| cause_q | output | 16 | Cause register contents |
| ret_err | output | 1 | Sticky flag: return with nothing saved |

## Verification
Random line patterns with random masks exercise selection with many simultaneous candidates, so a wrong priority direction or a missing mask term shows up. Directed ascending nesting, from source 0 up to source 7, fills the stack to its depth and then unwinds it. This separates a correct stack from one that restores the wrong entry or loses the nesting flag. A take with full stack, takes with the enable off and returns on an empty stack check the cases that must leave state untouched. Mixed strobes in the same cycle check the precedence order.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int STAT_IE  = 0;
  localparam int STAT_EXL = 1;
  localparam int STAT_UM  = 4;
  localparam int FLD_LO   = 8;

  typedef enum logic [1:0] {OP_NONE, OP_TAKE, OP_RET, OP_WRITE} irqc_op_e;
endpackage

// File: rtl/irqc_prio.sv
module irqc_prio #(
  parameter int N  = 8,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  vec,
  output logic          any,
  output logic [IW-1:0] idx,
  output logic [N-1:0]  above
);
  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (vec[i]) idx = IW'(i);
    end
  end

  assign any = |vec;

  generate
    for (genvar g = 0; g < N; g++) begin : g_above
      assign above[g] = (g > int'(idx));
    end
  endgenerate
endmodule

// File: rtl/irqc_mask_stack.sv
module irqc_mask_stack #(
  parameter int W     = 8,
  parameter int DEPTH = 8,
  parameter int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  parameter int PW    = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full,
  output logic         last
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] cnt_q, cnt_d, tidx;
  logic          do_push, do_pop;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == PW'(DEPTH));
  assign last    = (cnt_q == PW'(1));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign tidx    = cnt_q - PW'(1);
  assign dout    = empty ? '0 : mem[tidx[AW-1:0]];

  always_comb begin
    cnt_d = cnt_q;
    if (do_push)     cnt_d = cnt_q + PW'(1);
    else if (do_pop) cnt_d = cnt_q - PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt_q <= '0;
    else if (do_push || do_pop)  cnt_q <= cnt_d;
  end

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
      always_ff @(posedge clk) begin
        if (do_push && (cnt_q == PW'(g))) mem[g] <= din;
      end
    end
  endgenerate
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
  parameter int NSRC  = 8,
  parameter int DEPTH = 8,
  parameter int IW    = (NSRC > 1) ? $clog2(NSRC) : 1,
  parameter int SW    = irqc_pkg::FLD_LO + NSRC
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] irq_lines,
  input  logic            status_we,
  input  logic [SW-1:0]   status_wdata,
  input  logic            take,
  input  logic            ret,
  output logic            irq_req,
  output logic [IW-1:0]   irq_id,
  output logic [SW-1:0]   status_q,
  output logic [SW-1:0]   cause_q,
  output logic            ret_err
);
  import irqc_pkg::*;

  logic [NSRC-1:0] pend_q, mask_q, mask_d, cand, above, saved;
  logic            ie_q, ie_d, exl_q, exl_d, um_q, um_d, err_q;
  logic [IW-1:0]   id_q, sel;
  logic            any, stk_empty, stk_full, stk_last;
  logic            take_ok, ret_ok, ret_bad, wr_ok, stat_en;
  irqc_op_e        op;

  assign cand = pend_q & mask_q & {NSRC{ie_q}};

  irqc_prio #(.N(NSRC), .IW(IW)) u_prio (
    .vec(cand), .any(any), .idx(sel), .above(above)
  );

  assign take_ok = take && !ret && any && !stk_full;
  assign ret_ok  = ret && !stk_empty;
  assign ret_bad = ret && stk_empty;
  assign wr_ok   = status_we && !ret && !take_ok;

  always_comb begin
    if (ret_ok)       op = OP_RET;
    else if (take_ok) op = OP_TAKE;
    else if (wr_ok)   op = OP_WRITE;
    else              op = OP_NONE;
  end

  irqc_mask_stack #(.W(NSRC), .DEPTH(DEPTH)) u_stack (
    .clk(clk), .rst_n(rst_n),
    .push(take_ok), .pop(ret_ok), .din(mask_q), .dout(saved),
    .empty(stk_empty), .full(stk_full), .last(stk_last)
  );

  always_comb begin
    mask_d = mask_q;
    ie_d   = ie_q;
    exl_d  = exl_q;
    um_d   = um_q;
    case (op)
      OP_RET: begin
        mask_d = saved;
        ie_d   = 1'b1;
        exl_d  = !stk_last;
      end
      OP_TAKE: begin
        mask_d = mask_q & above;
        ie_d   = 1'b1;
        exl_d  = 1'b1;
      end
      OP_WRITE: begin
        mask_d = status_wdata[SW-1:FLD_LO];
        ie_d   = status_wdata[STAT_IE];
        um_d   = status_wdata[STAT_UM];
      end
      default: ;
    endcase
  end

  assign stat_en = (op != OP_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      ie_q   <= 1'b0;
      exl_q  <= 1'b0;
      um_q   <= 1'b0;
    end else if (stat_en) begin
      mask_q <= mask_d;
      ie_q   <= ie_d;
      exl_q  <= exl_d;
      um_q   <= um_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= irq_lines;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   id_q <= '0;
    else if (any) id_q <= sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       err_q <= 1'b0;
    else if (ret_bad) err_q <= 1'b1;
  end

  always_comb begin
    status_q                   = '0;
    status_q[SW-1:FLD_LO]      = mask_q;
    status_q[STAT_IE]          = ie_q;
    status_q[STAT_EXL]         = exl_q;
    status_q[STAT_UM]          = um_q;
    cause_q                    = '0;
    cause_q[SW-1:FLD_LO]       = pend_q;
  end

  assign irq_req = any;
  assign irq_id  = id_q;
  assign ret_err = err_q;

  logic unused_wbits;
  assign unused_wbits = ^{status_wdata[FLD_LO-1:STAT_UM+1],
                          status_wdata[STAT_UM-1:STAT_IE+1]};
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
  parameter int NSRC = 8,
  parameter int IW   = (NSRC > 1) ? $clog2(NSRC) : 1,
  parameter int SW   = 8 + NSRC
) (
  input logic          clk,
  input logic          rst_n,
  input logic          take,
  input logic          ret,
  input logic          irq_req,
  input logic [IW-1:0] irq_id,
  input logic [SW-1:0] status_q,
  input logic [SW-1:0] cause_q,
  input logic          ret_err
);
  logic [NSRC-1:0] cand_c;
  assign cand_c = status_q[SW-1:8] & cause_q[SW-1:8] & {NSRC{status_q[0]}};

  p_no_req_disabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !status_q[0] |-> !irq_req);

  p_id_highest_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |=> (($past(cand_c) >> irq_id) == NSRC'(1)));

  p_take_masks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (take && irq_req && !ret && !status_q[1]) |=>
      (((status_q[SW-1:8] & $past(cand_c)) == '0) && status_q[1] && status_q[0]));

  p_bad_ret_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ret && !status_q[1]) |=> (ret_err && $stable(status_q)));

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ret_err |=> ret_err);
endmodule

bind irq_prio_ctrl irqc_checker #(.NSRC(NSRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .take(take), .ret(ret), .irq_req(irq_req),
  .irq_id(irq_id), .status_q(status_q), .cause_q(cause_q), .ret_err(ret_err)
);

// File: tb/irq_prio_ctrl_test.sv
`timescale 1ns/1ps
module irq_prio_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  lines_i = '0;
  logic        we_i = 1'b0;
  logic [15:0] wd_i = '0;
  logic        take_i = 1'b0;
  logic        ret_i = 1'b0;
  logic        irq_req;
  logic [2:0]  irq_id;
  logic [15:0] status_q, cause_q;
  logic        ret_err;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // reference state
  logic [7:0] pend_m, mask_m;
  logic       ie_m, exl_m, um_m, err_m;
  logic [2:0] id_m;
  logic [7:0] stk_m [8];
  int         depth_m;
  string      stag;

  irq_prio_ctrl uut (
    .clk(clk), .rst_n(rst_n), .irq_lines(lines_i), .status_we(we_i),
    .status_wdata(wd_i), .take(take_i), .ret(ret_i), .irq_req(irq_req),
    .irq_id(irq_id), .status_q(status_q), .cause_q(cause_q), .ret_err(ret_err)
  );

  always #10 clk = ~clk;

  function automatic int hi_of(logic [7:0] v);
    int r = 0;
    for (int i = 0; i < 8; i++) if (v[i]) r = i;
    return r;
  endfunction

  function automatic logic [15:0] stat_m();
    return {mask_m, 3'b000, um_m, 2'b00, exl_m, ie_m};
  endfunction

  function automatic logic req_m();
    return ie_m && ((pend_m & mask_m) != 8'h00);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    pend_m = '0; mask_m = '0; ie_m = 0; exl_m = 0; um_m = 0; err_m = 0;
    id_m = '0; depth_m = 0; stag = "R1";
  endtask

  task automatic model_step();
    logic [7:0] cand;
    bit any, t_ok, r_ok, r_bad, w_ok;
    int s;
    cand  = pend_m & mask_m & {8{ie_m}};
    any   = (cand != 0);
    s     = hi_of(cand);
    t_ok  = take_i && !ret_i && any && (depth_m < 8);
    r_ok  = ret_i && (depth_m > 0);
    r_bad = ret_i && (depth_m == 0);
    w_ok  = we_i && !ret_i && !t_ok;
    stag  = "R9";
    if (r_ok) begin
      depth_m--; mask_m = stk_m[depth_m]; ie_m = 1; exl_m = (depth_m != 0); stag = "R7";
    end else if (t_ok) begin
      stk_m[depth_m] = mask_m; depth_m++;
      for (int i = 0; i < 8; i++) if (i <= s) mask_m[i] = 1'b0;
      ie_m = 1; exl_m = 1; stag = "R5";
    end else if (w_ok) begin
      mask_m = wd_i[15:8]; ie_m = wd_i[0]; um_m = wd_i[4];
    end else if (take_i && !ret_i) stag = "R6";
    if (r_bad) begin err_m = 1; stag = "R8"; end
    if (any) id_m = 3'(s);
    pend_m = lines_i;
  endtask

  task automatic step_chk();
    @(posedge clk);
    model_step();
    @(negedge clk);
    chk("R2 cause", 32'(cause_q), {16'h0, pend_m, 8'h00});
    chk("R3 irq_req", 32'(irq_req), 32'(req_m()));
    chk("R4 irq_id", 32'(irq_id), 32'(id_m));
    chk({stag, " status"}, 32'(status_q), 32'(stat_m()));
    chk("R8 ret_err", 32'(ret_err), 32'(err_m));
    lines_i = '0; we_i = 0; take_i = 0; ret_i = 0;
  endtask

  task automatic do_write(logic [15:0] d, logic [7:0] l);
    we_i = 1; wd_i = d; lines_i = l; step_chk();
  endtask

  initial begin
    #(20 * 50000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7341));
    model_reset();
    #35;
    // R1 reset state
    chk("R1 req", 32'(irq_req), 0);
    chk("R1 id", 32'(irq_id), 0);
    chk("R1 status", 32'(status_q), 0);
    chk("R1 cause", 32'(cause_q), 0);
    chk("R1 err", 32'(ret_err), 0);
    @(negedge clk); rst_n = 1;
    step_chk();

    // R8: return with nothing saved
    ret_i = 1; step_chk();
    chk("R8 sticky", 32'(ret_err), 1);

    // R3: lines active but enable off; R6: take ignored
    do_write(16'hFF00, 8'hFF);
    step_chk();
    chk("R3 disabled", 32'(irq_req), 0);
    take_i = 1; lines_i = 8'hFF; step_chk();
    chk("R6 status", 32'(status_q), 32'h0000FF00);

    // R9: write ignores reserved bits and nesting flag
    do_write(16'hFFFF, 8'h81);
    chk("R9 write", 32'(status_q), 32'h0000FF11);
    lines_i = 8'h81; step_chk();
    chk("R4 id top", 32'(irq_id), 7);
    take_i = 1; lines_i = 8'h81; step_chk();
    chk("R5 mask", 32'(status_q[15:8]), 0);
    ret_i = 1; step_chk();
    chk("R7 restore", 32'(status_q), 32'h0000FF11);

    // R5/R7: ascending nesting to full depth
    for (int k = 0; k < 8; k++) begin
      lines_i = 8'((1 << (k + 1)) - 1); step_chk();
      take_i = 1; lines_i = 8'((1 << (k + 1)) - 1); step_chk();
    end
    chk("R5 full mask", 32'(status_q[15:8]), 0);
    // R6: take with stack full is ignored
    do_write(16'hFF01, 8'hFF);
    lines_i = 8'hFF; step_chk();
    take_i = 1; lines_i = 8'hFF; step_chk();
    chk("R6 full", 32'(status_q), 32'h0000FF03);
    for (int k = 0; k < 8; k++) begin
      ret_i = 1; step_chk();
    end
    chk("R7 unwound", 32'(status_q[1]), 0);

    // random mix
    for (int n = 0; n < 4000; n++) begin
      int r = int'($urandom_range(99));
      lines_i = 8'($urandom);
      take_i  = (r < 35);
      ret_i   = (r >= 30 && r < 52);
      we_i    = (r >= 50 && r < 62);
      wd_i    = 16'($urandom) | 16'h0001;
      step_chk();
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule